// File: doc/BRIEF.md
# PHY Link and Activity Status Indicator

This block drives the three status lamps of a 10/100 Ethernet PHY: one for traffic, one for a good 100 Mb/s link and one for a good 10 Mb/s link. Each output is active low, so the pin is pulled low while its condition holds. The block sits after the analog receive front end. It receives the internal 100 Mb/s signal-detect level and single-cycle strobes for a received normal link pulse, a received valid 10BASE-T packet, transmit activity and receive activity. A one-cycle tick marks each microsecond, and every delay is counted in those ticks.

The two link indications behave differently. The 100 Mb/s indication waits until signal detect has stayed high for a qualification period, and it drops in the same cycle that signal detect falls. The 10 Mb/s indication comes up after a run of closely spaced link pulses, or at once on a valid packet. After that it holds until a link-loss period passes with neither pulses nor packets. The activity lamp is stretched after each event for a hold time, so that short bursts stay visible.

Top module: `phy_led_status`

## Requirements
- R1: After reset is released, all three outputs are high (dark) until a qualifying condition occurs.
- R2: `led_link100_n` goes low in the cycle after the QUAL_TICKS-th tick seen while `sig_det_100` has been high without a break. Any low cycle of `sig_det_100` restarts the count at zero.
- R3: Whenever `sig_det_100` is low, `led_link100_n` is high in that same cycle. There is no register between them.
- R4: While the 10 Mb/s link is down, `led_link10_n` goes low in the cycle after the NEED_PULSES-th consecutive link pulse of a run.
- R5: While the 10 Mb/s link is down, a run of pulses survives a spacing of up to GAP_TICKS ticks. On the (GAP_TICKS+1)-th tick with no pulse, the run count returns to zero, and the next pulse counts as the first of a new run.
- R6: A valid-packet strobe brings `led_link10_n` low in the following cycle, whatever the pulse count.
- R7: While the 10 Mb/s link is up, it drops and `led_link10_n` goes high in the cycle after the LOSS_TICKS-th tick with no pulse or packet. Each pulse or packet restarts that count.
- R8: A transmit or receive activity strobe brings `led_act_n` low in the following cycle.
- R9: `led_act_n` stays low until HOLD_TICKS ticks have passed since the last activity strobe. It goes high in the cycle after the HOLD_TICKS-th such tick.
- R10: The consecutive-pulse count never exceeds NEED_PULSES-1. Reaching NEED_PULSES brings the link up and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| sig_det_100 | input | 1 | 100 Mb/s signal-detect level |
| nlp_strobe | input | 1 | One-cycle strobe per received normal link pulse |
| pkt10_strobe | input | 1 | One-cycle strobe per valid 10BASE-T packet |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| led_act_n | output | 1 | Activity indication, low = active |
| led_link100_n | output | 1 | 100 Mb/s link indication, low = link good |
| led_link10_n | output | 1 | 10 Mb/s link indication, low = link good |

## Verification
A wrong qualification counter appears as a 100 Mb/s lamp that lights one or more ticks early or late. It also appears if the lamp lights after a break in signal detect, which should have restarted the count. The bench sweeps the tick count across the boundary to catch either error within a single qualification period. A stuck run or gap counter in the 10 Mb/s path shows as a link raised by too few pulses, or raised across a gap that should have broken the run. A faulty loss counter shows as a link that drops one tick off the boundary, or does not drop at all. The hold counter is exposed in the same way by sweeping the tick count after each strobe.

// File: rtl/led_status_pkg.sv
// Package: shared types and width helper for the PHY status indicator.
// Assumes: counters are sized to hold values 0..n inclusive.
package led_status_pkg;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_state_e;

    // Bits needed to hold the value n (at least one bit).
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/led_link100_qual.sv
// Module: 100 Mb/s link qualifier.
// Raises the link once signal detect has stayed high for QUAL_TICKS timebase
// ticks. Drops the link combinationally when signal detect falls.
// Assumes: QUAL_TICKS >= 1; tick lasts one cycle.
module led_link100_qual
    import led_status_pkg::*;
#(
    parameter int QUAL_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sig_det,
    output logic link_ok
);
    localparam int QW = cnt_w(QUAL_TICKS);
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_TICKS - 1);

    logic [QW-1:0] qcnt;
    logic          qualified;

    // Count ticks of unbroken signal detect; latch qualified at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qcnt      <= '0;
            qualified <= 1'b0;
        end else if (!sig_det) begin
            qcnt      <= '0;
            qualified <= 1'b0;
        end else if (tick && !qualified) begin
            if (qcnt == Q_LAST) begin
                qcnt      <= '0;
                qualified <= 1'b1;
            end else begin
                qcnt <= qcnt + 1'b1;
            end
        end
    end

    // Drop without a register stage when the detector falls.
    always_comb link_ok = qualified & sig_det;

    p_qual_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(sig_det && tick));

    p_qcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt <= Q_LAST);

endmodule

// File: rtl/led_link10_mon.sv
// Module: 10 Mb/s link monitor.
// While down, counts consecutive link pulses spaced no more than GAP_TICKS
// apart and raises the link at NEED_PULSES, or at once on a valid packet.
// While up, drops the link after LOSS_TICKS ticks with no pulse or packet.
// Assumes: NEED_PULSES >= 1, GAP_TICKS >= 1, LOSS_TICKS >= 1.
module led_link10_mon
    import led_status_pkg::*;
#(
    parameter int NEED_PULSES = 7,
    parameter int GAP_TICKS   = 24000,
    parameter int LOSS_TICKS  = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic nlp,
    input  logic pkt,
    output logic link_up
);
    localparam int PW = cnt_w(NEED_PULSES);
    localparam int GW = cnt_w(GAP_TICKS);
    localparam int LW = cnt_w(LOSS_TICKS);
    localparam logic [PW-1:0] P_LAST = PW'(NEED_PULSES - 1);
    localparam logic [GW-1:0] G_MAX  = GW'(GAP_TICKS);
    localparam logic [LW-1:0] L_LAST = LW'(LOSS_TICKS - 1);

    link_state_e   st;
    logic [PW-1:0] pcnt;
    logic [GW-1:0] gcnt;
    logic [LW-1:0] lcnt;

    // Link state, consecutive-pulse run, gap timer and loss timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= LNK_DOWN;
            pcnt <= '0;
            gcnt <= '0;
            lcnt <= '0;
        end else begin
            case (st)
                LNK_DOWN: begin
                    lcnt <= '0;
                    if (pkt) begin
                        st   <= LNK_UP;
                        pcnt <= '0;
                        gcnt <= '0;
                    end else if (nlp) begin
                        gcnt <= '0;
                        if (pcnt == P_LAST) begin
                            st   <= LNK_UP;
                            pcnt <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end else if (tick && pcnt != '0) begin
                        if (gcnt == G_MAX) begin
                            pcnt <= '0;
                            gcnt <= '0;
                        end else begin
                            gcnt <= gcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    pcnt <= '0;
                    gcnt <= '0;
                    if (pkt || nlp) begin
                        lcnt <= '0;
                    end else if (tick) begin
                        if (lcnt == L_LAST) begin
                            st   <= LNK_DOWN;
                            lcnt <= '0;
                        end else begin
                            lcnt <= lcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_comb link_up = (st == LNK_UP);

    p_up_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(nlp || pkt));

    p_gap_clears_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && tick && !nlp && !pkt && pcnt != '0 && gcnt == G_MAX)
            |=> (pcnt == '0));

    p_pkt_links_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt |=> link_up);

    p_loss_on_quiet_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |-> $past(tick && !nlp && !pkt));

    p_run_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= P_LAST);

endmodule

// File: rtl/led_act_stretch.sv
// Module: activity pulse stretcher.
// Each activity strobe reloads a hold counter. The lamp is lit while the
// counter is non-zero, and the counter falls by one per tick.
// Assumes: HOLD_TICKS >= 1.
module led_act_stretch
    import led_status_pkg::*;
#(
    parameter int HOLD_TICKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic act,
    output logic lit
);
    localparam int HW = cnt_w(HOLD_TICKS);
    localparam logic [HW-1:0] H_LOAD = HW'(HOLD_TICKS);

    logic [HW-1:0] hcnt;

    // Reload on activity, otherwise count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (act) begin
            hcnt <= H_LOAD;
        end else if (tick && hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
        end
    end

    always_comb lit = (hcnt != '0);

    p_act_lights_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> lit);

    p_hold_ends_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lit) |-> $past(tick && !act));

endmodule

// File: rtl/phy_led_status.sv
// Module: top of the PHY status indicator.
// Joins the 100 Mb/s qualifier, the 10 Mb/s monitor and the activity
// stretcher, and inverts their outputs to active-low lamp drives.
// Assumes: us_tick lasts one cycle; all strobes are synchronous to clk.
module phy_led_status #(
    parameter int QUAL_TICKS  = 500,
    parameter int NEED_PULSES = 7,
    parameter int GAP_TICKS   = 24000,
    parameter int LOSS_TICKS  = 150000,
    parameter int HOLD_TICKS  = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic sig_det_100,
    input  logic nlp_strobe,
    input  logic pkt10_strobe,
    input  logic tx_act,
    input  logic rx_act,
    output logic led_act_n,
    output logic led_link100_n,
    output logic led_link10_n
);
    logic ok100;
    logic up10;
    logic act_lit;
    logic any_act;

    // Either direction counts as activity.
    always_comb any_act = tx_act | rx_act;

    led_link100_qual #(.QUAL_TICKS(QUAL_TICKS)) u_q100 (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .sig_det(sig_det_100), .link_ok(ok100)
    );

    led_link10_mon #(
        .NEED_PULSES(NEED_PULSES), .GAP_TICKS(GAP_TICKS), .LOSS_TICKS(LOSS_TICKS)
    ) u_m10 (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .nlp(nlp_strobe), .pkt(pkt10_strobe), .link_up(up10)
    );

    led_act_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_act (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .act(any_act), .lit(act_lit)
    );

    // Active-low lamp drives.
    always_comb begin
        led_act_n     = ~act_lit;
        led_link100_n = ~ok100;
        led_link10_n  = ~up10;
    end

    p_reset_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (led_act_n && led_link100_n && led_link10_n));

    p_drop_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_det_100 |-> led_link100_n);

endmodule

// File: tb/phy_led_status_test.sv
// Bench: sweeps tick counts across each timer boundary on a small configuration.
module phy_led_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 6;
    localparam int NEED = 5;
    localparam int GAP  = 4;
    localparam int LOSS = 9;
    localparam int HOLD = 3;
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, sig_det_100 = 1'b0, nlp_strobe = 1'b0;
    logic pkt10_strobe = 1'b0, tx_act = 1'b0, rx_act = 1'b0;
    logic led_act_n, led_link100_n, led_link10_n;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_led_status #(
        .QUAL_TICKS(QUAL), .NEED_PULSES(NEED), .GAP_TICKS(GAP),
        .LOSS_TICKS(LOSS), .HOLD_TICKS(HOLD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sig_det_100(sig_det_100),
        .nlp_strobe(nlp_strobe), .pkt10_strobe(pkt10_strobe),
        .tx_act(tx_act), .rx_act(rx_act), .led_act_n(led_act_n),
        .led_link100_n(led_link100_n), .led_link10_n(led_link10_n)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // One clock: drive strobes after the falling edge, sample just after the rising edge.
    task automatic cyc(input logic t, input logic n, input logic p,
                       input logic x, input logic r);
        @(negedge clk);
        us_tick = t; nlp_strobe = n; pkt10_strobe = p; tx_act = x; rx_act = r;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sig_det_100 = 1'b0;
        us_tick = 1'b0; nlp_strobe = 1'b0; pkt10_strobe = 1'b0;
        tx_act = 1'b0; rx_act = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            checks++; fails++;
            $display("FAIL watchdog (all R): got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: all lamps dark after reset
        chk(led_act_n, 1'b1, "R1 act");
        chk(led_link100_n, 1'b1, "R1 link100");
        chk(led_link10_n, 1'b1, "R1 link10");

        // R2 / R3: qualification sweep, then immediate drop
        for (int k = 0; k <= QUAL + 1; k++) begin
            do_reset();
            @(negedge clk); sig_det_100 = 1'b1;
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            ticks(k);
            chk(led_link100_n, (k >= QUAL) ? 1'b0 : 1'b1, "R2 qual sweep");
            @(negedge clk); sig_det_100 = 1'b0; #1;
            chk(led_link100_n, 1'b1, "R3 immediate drop");
        end
        // R2: a break in signal detect restarts the count
        do_reset();
        @(negedge clk); sig_det_100 = 1'b1;
        ticks(QUAL - 1);
        @(negedge clk); sig_det_100 = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk); sig_det_100 = 1'b1;
        ticks(QUAL - 1);
        chk(led_link100_n, 1'b1, "R2 break restarts");
        ticks(1);
        chk(led_link100_n, 1'b0, "R2 full run after break");

        // R4 / R10: pulse runs of length n at spacing 1 and GAP
        for (int sp = 0; sp < 2; sp++) begin
            for (int n = 1; n <= NEED + 1; n++) begin
                do_reset();
                for (int i = 0; i < n; i++) begin
                    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
                    if (i < n - 1) ticks(sp == 0 ? 1 : GAP);
                end
                chk(led_link10_n, (n >= NEED) ? 1'b0 : 1'b1, "R4 pulse run");
            end
        end

        // R5: a gap one tick too long breaks the run
        do_reset();
        for (int i = 0; i < NEED - 1; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0); ticks(1);
        end
        ticks(GAP);
        for (int i = 0; i < NEED - 1; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0); ticks(1);
        end
        chk(led_link10_n, 1'b1, "R5 run broken by gap");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(led_link10_n, 1'b0, "R5 new run completes");

        // R6 / R7: packet raises link, loss timer boundary
        do_reset();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(led_link10_n, 1'b0, "R6 packet links");
        ticks(LOSS - 1);
        chk(led_link10_n, 1'b0, "R7 before loss");
        ticks(1);
        chk(led_link10_n, 1'b1, "R7 loss expiry");
        // R7: a pulse while up restarts the loss count
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(LOSS - 1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ticks(LOSS - 1);
        chk(led_link10_n, 1'b0, "R7 refresh by pulse");
        ticks(1);
        chk(led_link10_n, 1'b1, "R7 expiry after refresh");

        // R8 / R9: activity hold sweep, alternating direction
        for (int k = 0; k <= HOLD + 1; k++) begin
            do_reset();
            cyc(1'b0, 1'b0, 1'b0, k[0], ~k[0]);
            if (k == 0) chk(led_act_n, 1'b0, "R8 activity lights");
            ticks(k);
            chk(led_act_n, (k >= HOLD) ? 1'b1 : 1'b0, "R9 hold sweep");
        end
        // R9: repeated activity restarts the hold
        do_reset();
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        ticks(HOLD - 1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        ticks(HOLD - 1);
        chk(led_act_n, 1'b0, "R9 hold restarted");
        ticks(1);
        chk(led_act_n, 1'b1, "R9 hold expires");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule